// File: doc/BRIEF.md
# 8b/10b Line Encoder with Comma Start-up

This block turns a stream of bytes, each tagged as a data or a control character, into 10-bit DC-balanced code groups for a serial transmit lane. It keeps the running disparity across code groups. Each byte is split into a 5-bit and a 3-bit sub-block. Each sub-block picks its positive or negative form from the disparity left by the one before it. Code groups leave on `code_out` with bit 9 as line bit a and bit 0 as line bit j, in the order a b c d e i f g h j. A byte uses bits 4:0 for the 5-bit sub-block (EDCBA) and bits 7:5 for the 3-bit sub-block (HGF).

The lane reset is synchronous. While it is held, the block sends a negative-disparity K28.5 comma on every cycle and ignores its inputs. Once reset drops, it sends a fixed run of three commas, starting from negative disparity, so that the far end can lock. Only then does it start taking bytes.

The byte input is a valid/ready stream. A byte is taken on a rising clock edge where `in_valid` and `in_ready` are both high. The encoded group appears on `code_out` after that same edge. `in_ready` is low during reset and during the comma start-up. After that it stays high: once running, the encoder takes a byte on every cycle and never applies back-pressure. A source that holds `in_valid` high while `in_ready` is low keeps its byte, and that byte is taken on the first ready cycle. On a cycle with no valid byte, the encoder sends a K28.5 idle.

Top module: `linecode_tx`

## Requirements
- R1: On every rising edge where `rst` is high, `code_out` is loaded with 10'b0011111010 (K28.5, negative column), `code_err` is cleared, and `in_ready` goes low. The values of `in_data`, `in_ctrl` and `in_valid` have no effect on any output while `rst` is high.
- R2: The first three edges with `rst` low put out 10'b0011111010, 10'b1100000101 and 10'b0011111010, in that order. The running disparity is positive after the third of these.
- R3: `in_ready` is low from the first reset edge until three start-up commas have been sent, and high from then on until the next reset. A byte is taken on an edge where `in_valid` and `in_ready` are both high, and its code group is on `code_out` right after that edge.
- R4: A taken byte with `in_ctrl` low is encoded as data. The 6-bit sub-block abcdei comes from bits 4:0 and the 4-bit sub-block fghj comes from bits 7:5. Each sub-block is inverted from its negative-column form when the running disparity it starts from is positive. This inversion applies to the unbalanced forms, to D.7 in the 6-bit table and to D.x.3 in the 4-bit table.
- R5: For data bytes with bits 7:5 equal to 7, fghj uses the alternate form (0111 in the negative column, 1000 in the positive column). This applies when bits 4:0 are 17, 18 or 20 with negative disparity after abcdei, and when bits 4:0 are 11, 13 or 14 with positive disparity after abcdei. All other D.x.7 bytes use 1110/0001.
- R6: With `in_ctrl` high, exactly twelve bytes are valid control characters: 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC and 0xFC (K28.0 to K28.7), plus 0xF7, 0xFB, 0xFD and 0xFE (K23.7, K27.7, K29.7, K30.7). Each is sent as its standard code group for the current disparity, and `code_err` stays low.
- R7: A taken byte with `in_ctrl` high that is not one of the twelve valid control characters is sent as K28.5 for the current disparity (0011111010 for negative, 1100000101 for positive). `code_err` is high for exactly that output cycle.
- R8: On an edge after start-up where `in_valid` is low, the block sends K28.5 for the current disparity and `code_err` is low.
- R9: Outside reset, every code group has four, five or six ones. A group with six ones only follows negative running disparity, and a group with four ones only follows positive running disparity. The running disparity flips after each group that does not have exactly five ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Lane clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous lane reset, active high |
| in_data | input | 8 | Byte to encode: HGF in bits 7:5, EDCBA in bits 4:0 |
| in_ctrl | input | 1 | High marks `in_data` as a control character |
| in_valid | input | 1 | Stream valid for `in_data`/`in_ctrl` |
| in_ready | output | 1 | Stream ready; low in reset and during the comma start-up |
| code_out | output | 10 | Registered code group, bit 9 = a ... bit 0 = j |
| code_err | output | 1 | High for one group when an invalid control byte was replaced |

## Verification
On every cycle, the assertions check the parts of the behaviour that hold at all times. These are the reset comma and reset-low ready, and the start-up count before ready rises. They also cover the ready flag staying high once running, and the fact that an error or an idle can only show as a K28.5. The disparity check keeps its own tally of running disparity from the output alone and holds every group against it. The exact bit pattern of each data and control code group cannot be checked that way. Neither can the choice of alternate D.x.7 forms or the order of the start-up commas. The bench's scoreboard shows these: it drives all 256 data bytes, all twelve control characters, invalid control bytes, idle gaps, a mid-stream reset and a pseudo-random stream, and compares against a model built from full dual-column tables.

// File: rtl/linecode_pkg.sv
package linecode_pkg;

  localparam logic [9:0] K285_NEG  = 10'b0011111010;
  localparam logic [9:0] K285_POS  = 10'b1100000101;
  localparam logic [7:0] K285_BYTE = 8'hBC;
  localparam logic [5:0] K28_SIX   = 6'b001111;

  // Negative-column abcdei for each EDCBA value.
  function automatic logic [5:0] six_neg(input logic [4:0] x);
    logic [5:0] r;
    case (x)
      5'd0:  r = 6'b100111;  5'd1:  r = 6'b011101;
      5'd2:  r = 6'b101101;  5'd3:  r = 6'b110001;
      5'd4:  r = 6'b110101;  5'd5:  r = 6'b101001;
      5'd6:  r = 6'b011001;  5'd7:  r = 6'b111000;
      5'd8:  r = 6'b111001;  5'd9:  r = 6'b100101;
      5'd10: r = 6'b010101;  5'd11: r = 6'b110100;
      5'd12: r = 6'b001101;  5'd13: r = 6'b101100;
      5'd14: r = 6'b011100;  5'd15: r = 6'b010111;
      5'd16: r = 6'b011011;  5'd17: r = 6'b100011;
      5'd18: r = 6'b010011;  5'd19: r = 6'b110010;
      5'd20: r = 6'b001011;  5'd21: r = 6'b101010;
      5'd22: r = 6'b011010;  5'd23: r = 6'b111010;
      5'd24: r = 6'b110011;  5'd25: r = 6'b100110;
      5'd26: r = 6'b010110;  5'd27: r = 6'b110110;
      5'd28: r = 6'b001110;  5'd29: r = 6'b101110;
      5'd30: r = 6'b011110;  default: r = 6'b101011;
    endcase
    return r;
  endfunction

  // Negative-column fghj for data; alt selects the run-breaking D.x.7 form.
  function automatic logic [3:0] four_neg(input logic [2:0] y, input logic alt);
    logic [3:0] r;
    case (y)
      3'd0: r = 4'b1011;  3'd1: r = 4'b1001;
      3'd2: r = 4'b0101;  3'd3: r = 4'b1100;
      3'd4: r = 4'b1101;  3'd5: r = 4'b1010;
      3'd6: r = 4'b0110;  default: r = alt ? 4'b0111 : 4'b1110;
    endcase
    return r;
  endfunction

  // fghj of K28.y when abcdei left positive disparity.
  function automatic logic [3:0] k28_four_pos(input logic [2:0] y);
    logic [3:0] r;
    case (y)
      3'd0: r = 4'b0100;  3'd1: r = 4'b1001;
      3'd2: r = 4'b0101;  3'd3: r = 4'b0011;
      3'd4: r = 4'b0010;  3'd5: r = 4'b1010;
      3'd6: r = 4'b0110;  default: r = 4'b1000;
    endcase
    return r;
  endfunction

  function automatic logic kchar_ok(input logic [7:0] b);
    logic [4:0] x;
    x = b[4:0];
    return (x == 5'd28) ||
           ((b[7:5] == 3'd7) &&
            (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30));
  endfunction

endpackage

// File: rtl/linecode_enc6.sv
module linecode_enc6
  import linecode_pkg::*;
(
  input  logic [4:0] x,
  input  logic       is_k28,
  input  logic       rd_in,
  output logic [5:0] code6,
  output logic       rd_out
);
  logic [5:0] base;
  logic       bal;
  logic       flip;

  always_comb begin
    base   = is_k28 ? K28_SIX : six_neg(x);
    bal    = ($countones(base) == 3);
    // D.7 is balanced yet still has a positive-column form
    flip   = rd_in & (~bal | (x == 5'd7));
    code6  = flip ? ~base : base;
    rd_out = rd_in ^ ~bal;
  end
endmodule

// File: rtl/linecode_enc4.sv
module linecode_enc4
  import linecode_pkg::*;
(
  input  logic [2:0] y,
  input  logic       is_k28,
  input  logic       alt,
  input  logic       rd_in,
  output logic [3:0] code4,
  output logic       rd_out
);
  logic [3:0] base;
  logic       bal;
  logic       flip;

  always_comb begin
    if (is_k28) begin
      base = k28_four_pos(y);
      flip = ~rd_in;
    end else begin
      base = four_neg(y, alt);
      flip = rd_in & (($countones(base) != 2) | (y == 3'd3));
    end
    code4  = flip ? ~base : base;
    bal    = ($countones(code4) == 2);
    rd_out = rd_in ^ ~bal;
  end
endmodule

// File: rtl/linecode_tx_seq.sv
module linecode_tx_seq #(
  parameter int PREAMBLE_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  output logic run
);
  localparam int CNT_W = (PREAMBLE_LEN < 1) ? 1 : $clog2(PREAMBLE_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PREAMBLE_LEN);

  logic [CNT_W-1:0] sent_q;

  always_ff @(posedge clk) begin
    if (rst)                sent_q <= '0;
    else if (sent_q != LAST) sent_q <= sent_q + 1'b1;
  end

  assign run = (sent_q == LAST);
endmodule

// File: rtl/linecode_tx.sv
module linecode_tx
  import linecode_pkg::*;
#(
  parameter int PREAMBLE_LEN = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] in_data,
  input  logic       in_ctrl,
  input  logic       in_valid,
  output logic       in_ready,
  output logic [9:0] code_out,
  output logic       code_err
);
  logic       take, bad_k, use_in;
  logic [7:0] sel_byte;
  logic       sel_k, is_k28, alt;
  logic       rd_q, rd6, rd10;
  logic [5:0] code6;
  logic [3:0] code4;
  logic [9:0] code_q;
  logic       err_q;

  linecode_tx_seq #(.PREAMBLE_LEN(PREAMBLE_LEN)) u_seq (
    .clk (clk),
    .rst (rst),
    .run (in_ready)
  );

  always_comb begin
    take     = in_valid & in_ready;
    bad_k    = take & in_ctrl & ~kchar_ok(in_data);
    use_in   = take & ~bad_k;
    sel_byte = use_in ? in_data : K285_BYTE;
    sel_k    = use_in ? in_ctrl : 1'b1;
    is_k28   = sel_k & (sel_byte[4:0] == 5'd28);
  end

  linecode_enc6 u_enc6 (
    .x      (sel_byte[4:0]),
    .is_k28 (is_k28),
    .rd_in  (rd_q),
    .code6  (code6),
    .rd_out (rd6)
  );

  always_comb begin
    if (sel_k) alt = 1'b1;
    else if (rd6)
      alt = (sel_byte[4:0] == 5'd11) | (sel_byte[4:0] == 5'd13) | (sel_byte[4:0] == 5'd14);
    else
      alt = (sel_byte[4:0] == 5'd17) | (sel_byte[4:0] == 5'd18) | (sel_byte[4:0] == 5'd20);
  end

  linecode_enc4 u_enc4 (
    .y      (sel_byte[7:5]),
    .is_k28 (is_k28),
    .alt    (alt),
    .rd_in  (rd6),
    .code4  (code4),
    .rd_out (rd10)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= K285_NEG;
      rd_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      code_q <= {code6, code4};
      rd_q   <= rd10;
      err_q  <= bad_k;
    end
  end

  assign code_out = code_q;
  assign code_err = err_q;
endmodule

// File: rtl/linecode_tx_chk.sv
module linecode_tx_chk #(
  parameter int PREAMBLE_LEN = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic [9:0] code_out,
  input logic       code_err
);
  localparam logic [9:0] KN = 10'b0011111010;
  localparam logic [9:0] KP = 10'b1100000101;

  logic primed   = 1'b0;
  logic past_rst = 1'b0;
  logic rd_chk   = 1'b0;
  int   since_rst = 0;
  int   ones;

  assign ones = $countones(code_out);

  always_ff @(posedge clk) begin
    primed   <= 1'b1;
    past_rst <= rst;
    if (rst) begin
      rd_chk    <= 1'b0;
      since_rst <= 0;
    end else begin
      if (!past_rst) rd_chk <= rd_chk ^ (ones != 5);
      if (since_rst < PREAMBLE_LEN) since_rst <= since_rst + 1;
    end
  end

  AST_RESET_COMMA: assert property (@(posedge clk) disable iff (!primed)
    past_rst |-> (code_out == KN && !code_err)); // R1
  AST_RESET_NOT_READY: assert property (@(posedge clk) disable iff (!primed)
    past_rst |-> !in_ready); // R3
  AST_READY_AFTER_PREAMBLE: assert property (@(posedge clk) disable iff (rst || !primed)
    in_ready == (since_rst >= PREAMBLE_LEN)); // R3
  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst || !primed)
    in_ready |=> in_ready); // R3
  AST_DISPARITY_TRACK: assert property (@(posedge clk) disable iff (rst || past_rst || !primed)
    (ones >= 4 && ones <= 6) && (rd_chk ? ones <= 5 : ones >= 5)); // R9
  AST_ERR_IS_COMMA: assert property (@(posedge clk) disable iff (rst || !primed)
    code_err |-> (code_out == KN || code_out == KP)); // R7
  AST_IDLE_COMMA: assert property (@(posedge clk) disable iff (rst || !primed)
    (in_ready && !in_valid) |=> ((code_out == KN || code_out == KP) && !code_err)); // R8
endmodule

bind linecode_tx linecode_tx_chk #(.PREAMBLE_LEN(PREAMBLE_LEN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .code_out (code_out),
  .code_err (code_err)
);

// File: tb/test_linecode_tx.sv
module test_linecode_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic       in_ctrl = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [9:0] code_out;
  logic       code_err;

  int n_chk = 0;
  int n_fail = 0;

  logic [10:0] exp_q[$];
  string       tag_q[$];

  logic m_rd = 1'b0;
  int   m_cnt = 0;
  bit   m_known = 1'b0;

  always #4 clk = ~clk;

  linecode_tx i_linecode_tx (
    .clk(clk), .rst(rst), .in_data(in_data), .in_ctrl(in_ctrl),
    .in_valid(in_valid), .in_ready(in_ready), .code_out(code_out), .code_err(code_err)
  );

  task automatic check(input bit ok, input string tag, input logic [10:0] act, input logic [10:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [11:0] tab6(input logic [4:0] x);
    case (x)
      5'd0:  return {6'b100111, 6'b011000};  5'd1:  return {6'b011101, 6'b100010};
      5'd2:  return {6'b101101, 6'b010010};  5'd3:  return {6'b110001, 6'b110001};
      5'd4:  return {6'b110101, 6'b001010};  5'd5:  return {6'b101001, 6'b101001};
      5'd6:  return {6'b011001, 6'b011001};  5'd7:  return {6'b111000, 6'b000111};
      5'd8:  return {6'b111001, 6'b000110};  5'd9:  return {6'b100101, 6'b100101};
      5'd10: return {6'b010101, 6'b010101};  5'd11: return {6'b110100, 6'b110100};
      5'd12: return {6'b001101, 6'b001101};  5'd13: return {6'b101100, 6'b101100};
      5'd14: return {6'b011100, 6'b011100};  5'd15: return {6'b010111, 6'b101000};
      5'd16: return {6'b011011, 6'b100100};  5'd17: return {6'b100011, 6'b100011};
      5'd18: return {6'b010011, 6'b010011};  5'd19: return {6'b110010, 6'b110010};
      5'd20: return {6'b001011, 6'b001011};  5'd21: return {6'b101010, 6'b101010};
      5'd22: return {6'b011010, 6'b011010};  5'd23: return {6'b111010, 6'b000101};
      5'd24: return {6'b110011, 6'b001100};  5'd25: return {6'b100110, 6'b100110};
      5'd26: return {6'b010110, 6'b010110};  5'd27: return {6'b110110, 6'b001001};
      5'd28: return {6'b001110, 6'b001110};  5'd29: return {6'b101110, 6'b010001};
      5'd30: return {6'b011110, 6'b100001};  default: return {6'b101011, 6'b010100};
    endcase
  endfunction

  function automatic logic [7:0] tab4(input logic [2:0] y, input bit k28);
    if (k28) case (y)
      3'd0: return {4'b1011, 4'b0100};  3'd1: return {4'b0110, 4'b1001};
      3'd2: return {4'b1010, 4'b0101};  3'd3: return {4'b1100, 4'b0011};
      3'd4: return {4'b1101, 4'b0010};  3'd5: return {4'b0101, 4'b1010};
      3'd6: return {4'b1001, 4'b0110};  default: return {4'b0111, 4'b1000};
    endcase
    case (y)
      3'd0: return {4'b1011, 4'b0100};  3'd1: return {4'b1001, 4'b1001};
      3'd2: return {4'b0101, 4'b0101};  3'd3: return {4'b1100, 4'b0011};
      3'd4: return {4'b1101, 4'b0010};  3'd5: return {4'b1010, 4'b1010};
      3'd6: return {4'b0110, 4'b0110};  default: return {4'b1110, 4'b0001};
    endcase
  endfunction

  function automatic bit k_ok(input logic [7:0] b);
    return b == 8'h1C || b == 8'h3C || b == 8'h5C || b == 8'h7C || b == 8'h9C ||
           b == 8'hBC || b == 8'hDC || b == 8'hFC || b == 8'hF7 || b == 8'hFB ||
           b == 8'hFD || b == 8'hFE;
  endfunction

  task automatic ref_code(input logic [7:0] b, input bit k, output logic [9:0] c);
    logic [4:0] x;
    logic [11:0] p6;
    logic [7:0] p4;
    logic [5:0] c6;
    logic [3:0] c4;
    logic rd6;
    bit k28, alt;
    x   = b[4:0];
    k28 = k && x == 5'd28;
    p6  = k28 ? {6'b001111, 6'b110000} : tab6(x);
    c6  = m_rd ? p6[5:0] : p6[11:6];
    rd6 = m_rd ^ ($countones(c6) != 3);
    alt = k || (!rd6 && (x == 17 || x == 18 || x == 20)) || (rd6 && (x == 11 || x == 13 || x == 14));
    p4  = (!k28 && b[7:5] == 3'd7 && alt) ? {4'b0111, 4'b1000} : tab4(b[7:5], k28);
    c4  = rd6 ? p4[3:0] : p4[7:4];
    m_rd = rd6 ^ ($countones(c4) != 2);
    c = {c6, c4};
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic step(input bit r, input bit v, input bit k, input logic [7:0] d);
    logic [9:0] e;
    bit err;
    string tag;
    @(negedge clk);
    if (m_known)
      check(in_ready == (m_cnt == 3), "R3 ready", {10'd0, in_ready}, {10'd0, m_cnt == 3});
    rst = r; in_valid = v; in_ctrl = k; in_data = d;
    err = 1'b0;
    if (r) begin
      e = 10'b0011111010; m_rd = 1'b0; m_cnt = 0; m_known = 1'b1; tag = "R1 reset";
    end else if (m_cnt < 3) begin
      e = (m_cnt == 1) ? 10'b1100000101 : 10'b0011111010;
      m_rd = (m_cnt != 1);
      m_cnt++;
      tag = "R2 preamble";
    end else if (!v) begin
      ref_code(8'hBC, 1'b1, e); tag = "R8 idle";
    end else if (k && !k_ok(d)) begin
      ref_code(8'hBC, 1'b1, e); err = 1'b1; tag = "R7 bad control";
    end else begin
      ref_code(d, k, e);
      tag = k ? "R6 control" : (d[7:5] == 3'd7 ? "R5 data x.7" : "R4 data");
    end
    exp_q.push_back({err, e});
    tag_q.push_back(tag);
  endtask

  // Monitor: compares after each edge against the scoreboard head.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [10:0] ex;
      string t;
      ex = exp_q.pop_front();
      t  = tag_q.pop_front();
      check(code_out == ex[9:0], {t, " code (R9)"}, {1'b0, code_out}, {1'b0, ex[9:0]});
      check(code_err == ex[10], {t, " err"}, {10'd0, code_err}, {10'd0, ex[10]});
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    // R1: reset with live-looking inputs that must be ignored
    for (int i = 0; i < 4; i++) step(1, 1, i[0], 8'hA5 + 8'(i));
    // R2/R3: start-up with valid held, nothing taken yet
    for (int i = 0; i < 3; i++) step(0, 1, 0, 8'h55);
    // R4/R5: every data byte
    for (int i = 0; i < 256; i++) step(0, 1, 0, 8'(i));
    // R8: idle gap
    step(0, 0, 0, 8'h00); step(0, 0, 1, 8'hFF);
    // R6: all twelve control characters, twice for both disparities
    for (int p = 0; p < 2; p++) begin
      for (int y = 0; y < 8; y++) step(0, 1, 1, {3'(y), 5'd28});
      step(0, 1, 1, 8'hF7); step(0, 1, 1, 8'hFB);
      step(0, 1, 1, 8'hFD); step(0, 1, 1, 8'hFE);
    end
    // R7: invalid control bytes
    step(0, 1, 1, 8'h00); step(0, 1, 1, 8'hFF); step(0, 1, 1, 8'h3B); step(0, 1, 0, 8'h15);
    // R1 again: mid-stream reset, then a fresh start-up (R2)
    step(1, 1, 0, 8'h12); step(1, 0, 1, 8'h3C);
    for (int i = 0; i < 3; i++) step(0, 1, 1, 8'hBC);
    // Pseudo-random mix of data, controls and idles
    lfsr = 8'h5A;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(0, lfsr[1] | lfsr[6], lfsr[0] & lfsr[2] & lfsr[3], lfsr ^ 8'(i));
    end
    step(0, 0, 0, 8'h00);
    repeat (3) @(posedge clk);
    #3;
    summary();
    $finish;
  end
endmodule